// File: doc/BRIEF.md
# SDRAM Command Spacing Monitor

This block sits beside the command bus of a two-bank synchronous DRAM and only watches it. Each clock it sees one decoded command, the bank it targets and a strobe that marks a write data word on the bus. It checks that command against the timing rules of the memory: spacing between row openings, spacing from a row opening to a column access or a close, how long a row may stay open, and how soon after the last write data a read, a close or a burst stop may follow. A command that comes too early raises a one-cycle pulse on the output bit for that rule. A sticky code keeps the first rule that was broken until software-independent clear logic pulses the clear input.

All timing limits are given as nanosecond parameters together with the clock period in picoseconds. At elaboration each limit becomes a cycle count, so a slower speed grade only needs new parameter values. The monitor also tracks whether each bank is open. It flags commands that make no sense for the bank's state.

When a read burst is cut short by a close or a burst stop, the monitor reports how many data words the memory still drives. This count goes to a neighbouring data-path monitor.

Top module: `sdr_cmd_spacing_mon`

## Requirements
- R1: Each nanosecond limit becomes ceil(ns*1000 / CLK_PERIOD_PS) cycles. With the defaults (8000 ps clock) this gives 2 cycles bank-to-bank open spacing, 3 cycles open-to-column, 3 cycles close-to-open, 7 cycles minimum open time, 9 cycles open-to-open on one bank and 12500 cycles maximum open time. A command at distance d cycles from the one it is measured against violates a minimum when d is less than the count.
- R2: Synchronous active-high reset leaves both banks closed, all outputs zero and every distance counter saturated, so no first command after reset raises a violation.
- R3: An open (cmd 1) to a bank other than the one named by the most recent open, fewer cycles after that open than the bank-to-bank spacing, sets viol_o bit 1.
- R4: A read (cmd 2) or write (cmd 3) to an open bank fewer cycles after that bank was opened than the open-to-column count sets viol_o bit 2.
- R5: A close (cmd 4) to an open bank fewer cycles after it was opened than the minimum open time sets viol_o bit 4.
- R6: An open to a closed bank sets viol_o bit 3 when it comes fewer cycles after that bank's last close than the close-to-open count. It sets viol_o bit 6 when it comes fewer cycles after that bank's last open than the open-to-open count.
- R7: A bank that is still open exactly the maximum open time after it was opened, with no close to it in that cycle, sets viol_o bit 5 once.
- R8: In a cycle where wr_dv_i is high (zero cycles after the last write data), a read sets viol_o bit 7, a close sets bit 8 and a burst stop (cmd 5) sets bit 9. A write never raises these bits, so column commands may be issued on back-to-back cycles.
- R9: A read or write to a closed bank, or an open to an open bank, sets viol_o bit 0 and leaves the bank state unchanged. A close to a closed bank changes nothing.
- R10: A close or burst stop while the latest column command was a read pulses rd_cut_vld_o, with rd_cut_words_o equal to CAS_LAT-1 (2 at latency 3, 1 at latency 2).
- R11: err_code_o holds 0, or the code of the first violation seen since reset or the last clear, where the code is the lowest set viol_o bit index plus one. err_clr_i clears it, and a violation in the same cycle as the clear is captured as the new code.
- R12: viol_o, rd_cut_vld_o and err_code_o are registered and change on the clock edge after the command. Violation pulses last one cycle, and a NOP (cmd 0, codes 6 and 7 act alike) raises no bit other than bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Decoded command: 0 NOP, 1 open row, 2 read, 3 write, 4 close row, 5 burst stop |
| bank_i | input | BANK_W | Bank targeted by the command |
| wr_dv_i | input | 1 | A write data word is on the bus this cycle |
| err_clr_i | input | 1 | Clears the sticky error code |
| viol_o | output | 10 | One-cycle violation pulse per rule |
| err_code_o | output | 4 | Sticky code of the first violation, 0 if none |
| rd_cut_vld_o | output | 1 | A read burst was cut short this cycle |
| rd_cut_words_o | output | 2 | Data words still driven after the cut |

## Verification
The assertions check on every cycle that column commands never raise spacing bits that only opens or closes can raise, that opens never raise write-recovery or open-to-column bits, and that a NOP stays quiet apart from the open-time limit. They also check that the sticky code neither changes without a clear nor appears without a pulse, and that a cut report always carries the latency-derived word count. Whether each limit fires at exactly the right distance needs the bench's reference model: boundary distances one below and at each cycle count, the 12500-cycle open-time expiry, the state-misuse cases and a long random command stream.

// File: rtl/sdr_mon_pkg.sv
package sdr_mon_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_BST = 3'd5
  } cmd_e;

  localparam int NRULE         = 10;
  localparam int CODE_W        = 4;
  localparam int RULE_ILLEGAL  = 0;
  localparam int RULE_RRD      = 1;
  localparam int RULE_RCD      = 2;
  localparam int RULE_RP       = 3;
  localparam int RULE_RAS_MIN  = 4;
  localparam int RULE_RAS_MAX  = 5;
  localparam int RULE_RC       = 6;
  localparam int RULE_CDL      = 7;
  localparam int RULE_RDL      = 8;
  localparam int RULE_BDL      = 9;

  // round a nanosecond limit up to whole clock cycles
  function automatic int ns_to_cyc(input int ns, input int period_ps);
    return (ns * 1000 + period_ps - 1) / period_ps;
  endfunction

  // lowest set rule index plus one, zero when nothing is set
  function automatic logic [CODE_W-1:0] first_code(input logic [NRULE-1:0] v);
    logic [CODE_W-1:0] c;
    c = '0;
    for (int i = NRULE - 1; i >= 0; i--) begin
      if (v[i]) c = CODE_W'(i + 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/sdr_bank_track.sv
module sdr_bank_track
  import sdr_mon_pkg::*;
#(
  parameter int ACT_W      = 24,
  parameter int PRE_W      = 3,
  parameter int RCD_CYC    = 3,
  parameter int RP_CYC     = 3,
  parameter int RASMIN_CYC = 7,
  parameter int RASMAX_CYC = 12500,
  parameter int RC_CYC     = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_i,
  input  cmd_e             cmd_i,
  output logic [NRULE-1:0] hit_o
);

  localparam logic [ACT_W-1:0] RCD_L    = ACT_W'(RCD_CYC);
  localparam logic [ACT_W-1:0] RASMIN_L = ACT_W'(RASMIN_CYC);
  localparam logic [ACT_W-1:0] RASMAX_L = ACT_W'(RASMAX_CYC);
  localparam logic [ACT_W-1:0] RC_L     = ACT_W'(RC_CYC);
  localparam logic [PRE_W-1:0] RP_L     = PRE_W'(RP_CYC);

  logic             open_q;
  logic [ACT_W-1:0] since_act_q;
  logic [PRE_W-1:0] since_pre_q;
  logic             take_act;
  logic             take_pre;

  always_comb begin
    hit_o    = '0;
    take_act = 1'b0;
    take_pre = 1'b0;
    if (open_q && since_act_q == RASMAX_L && !(sel_i && cmd_i == CMD_PRE))
      hit_o[RULE_RAS_MAX] = 1'b1;
    if (sel_i) begin
      case (cmd_i)
        CMD_ACT: begin
          if (open_q) begin
            hit_o[RULE_ILLEGAL] = 1'b1;
          end else begin
            take_act = 1'b1;
            if (since_pre_q < RP_L) hit_o[RULE_RP] = 1'b1;
            if (since_act_q < RC_L) hit_o[RULE_RC] = 1'b1;
          end
        end
        CMD_RD, CMD_WR: begin
          if (!open_q)                 hit_o[RULE_ILLEGAL] = 1'b1;
          else if (since_act_q < RCD_L) hit_o[RULE_RCD]    = 1'b1;
        end
        CMD_PRE: begin
          if (open_q) begin
            take_pre = 1'b1;
            if (since_act_q < RASMIN_L) hit_o[RULE_RAS_MIN] = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q      <= 1'b0;
      since_act_q <= '1;
      since_pre_q <= '1;
    end else begin
      if (take_act)      open_q <= 1'b1;
      else if (take_pre) open_q <= 1'b0;

      if (take_act)              since_act_q <= ACT_W'(1);
      else if (since_act_q != '1) since_act_q <= since_act_q + 1'b1;

      if (take_pre)              since_pre_q <= PRE_W'(1);
      else if (since_pre_q != '1) since_pre_q <= since_pre_q + 1'b1;
    end
  end

endmodule

// File: rtl/sdr_bus_track.sv
module sdr_bus_track
  import sdr_mon_pkg::*;
#(
  parameter int BANK_W     = 1,
  parameter int RRD_CYC    = 2,
  parameter int RRD_W      = 3,
  parameter int WR_RCV_CYC = 1,
  parameter int WRC_W      = 2,
  parameter int CAS_LAT    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_e              cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              wr_dv_i,
  output logic [NRULE-1:0]  hit_o,
  output logic              cut_vld_o,
  output logic [1:0]        cut_words_o
);

  localparam logic [RRD_W-1:0] RRD_L = RRD_W'(RRD_CYC);
  localparam logic [WRC_W-1:0] WRC_L = WRC_W'(WR_RCV_CYC);

  logic [RRD_W-1:0]  since_any_act_q;
  logic [BANK_W-1:0] last_bank_q;
  logic [WRC_W-1:0]  since_wd_q;
  logic              rd_open_q;
  logic [WRC_W-1:0]  wd_dist;
  logic              wr_close;

  assign wd_dist     = wr_dv_i ? '0 : since_wd_q;
  assign wr_close    = wd_dist < WRC_L;
  assign cut_words_o = 2'(CAS_LAT - 1);
  assign cut_vld_o   = rd_open_q && (cmd_i == CMD_PRE || cmd_i == CMD_BST);

  always_comb begin
    hit_o = '0;
    if (cmd_i == CMD_ACT && bank_i != last_bank_q && since_any_act_q < RRD_L)
      hit_o[RULE_RRD] = 1'b1;
    if (wr_close) begin
      if (cmd_i == CMD_RD)  hit_o[RULE_CDL] = 1'b1;
      if (cmd_i == CMD_PRE) hit_o[RULE_RDL] = 1'b1;
      if (cmd_i == CMD_BST) hit_o[RULE_BDL] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      since_any_act_q <= '1;
      last_bank_q     <= '0;
      since_wd_q      <= '1;
      rd_open_q       <= 1'b0;
    end else begin
      if (cmd_i == CMD_ACT) begin
        since_any_act_q <= RRD_W'(1);
        last_bank_q     <= bank_i;
      end else if (since_any_act_q != '1) begin
        since_any_act_q <= since_any_act_q + 1'b1;
      end

      if (wr_dv_i)               since_wd_q <= WRC_W'(1);
      else if (since_wd_q != '1) since_wd_q <= since_wd_q + 1'b1;

      case (cmd_i)
        CMD_RD:                  rd_open_q <= 1'b1;
        CMD_WR, CMD_PRE, CMD_BST: rd_open_q <= 1'b0;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sdr_err_sticky.sv
module sdr_err_sticky
  import sdr_mon_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic [NRULE-1:0]  hit_i,
  output logic [CODE_W-1:0] code_o
);

  logic [CODE_W-1:0] new_code;

  assign new_code = first_code(hit_i);

  always_ff @(posedge clk) begin
    if (rst)                     code_o <= '0;
    else if (clr_i)              code_o <= new_code;
    else if (code_o == '0)       code_o <= new_code;
  end

endmodule

// File: rtl/sdr_cmd_spacing_mon.sv
module sdr_cmd_spacing_mon
  import sdr_mon_pkg::*;
#(
  parameter int NUM_BANKS     = 2,
  parameter int CLK_PERIOD_PS = 8000,
  parameter int T_RRD_NS      = 14,
  parameter int T_RCD_NS      = 21,
  parameter int T_RP_NS       = 21,
  parameter int T_RAS_MIN_NS  = 49,
  parameter int T_RC_NS       = 70,
  parameter int T_RAS_MAX_NS  = 100000,
  parameter int WR_RCV_CYC    = 1,
  parameter int CAS_LAT       = 3,
  localparam int BANK_W       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              wr_dv_i,
  input  logic              err_clr_i,
  output logic [9:0]        viol_o,
  output logic [3:0]        err_code_o,
  output logic              rd_cut_vld_o,
  output logic [1:0]        rd_cut_words_o
);

  localparam int RRD_CYC    = ns_to_cyc(T_RRD_NS, CLK_PERIOD_PS);
  localparam int RCD_CYC    = ns_to_cyc(T_RCD_NS, CLK_PERIOD_PS);
  localparam int RP_CYC     = ns_to_cyc(T_RP_NS, CLK_PERIOD_PS);
  localparam int RASMIN_CYC = ns_to_cyc(T_RAS_MIN_NS, CLK_PERIOD_PS);
  localparam int RC_CYC     = ns_to_cyc(T_RC_NS, CLK_PERIOD_PS);
  localparam int RASMAX_CYC = ns_to_cyc(T_RAS_MAX_NS, CLK_PERIOD_PS);
  localparam int ACT_NEED   = $clog2(RASMAX_CYC + 2);
  localparam int ACT_W      = (ACT_NEED > 24) ? ACT_NEED : 24;
  localparam int PRE_W      = $clog2(RP_CYC + 2);
  localparam int RRD_W      = $clog2(RRD_CYC + 2);
  localparam int WRC_W      = $clog2(WR_RCV_CYC + 2);

  cmd_e              cmd_c;
  logic [NRULE-1:0]  bank_hit [NUM_BANKS];
  logic [NRULE-1:0]  bus_hit;
  logic [NRULE-1:0]  all_hit;
  logic              cut_vld;
  logic [1:0]        cut_words;
  logic [CODE_W-1:0] code;

  assign cmd_c = cmd_e'(cmd_i);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdr_bank_track #(
      .ACT_W     (ACT_W),
      .PRE_W     (PRE_W),
      .RCD_CYC   (RCD_CYC),
      .RP_CYC    (RP_CYC),
      .RASMIN_CYC(RASMIN_CYC),
      .RASMAX_CYC(RASMAX_CYC),
      .RC_CYC    (RC_CYC)
    ) trk_i (
      .clk  (clk),
      .rst  (rst),
      .sel_i(bank_i == BANK_W'(b)),
      .cmd_i(cmd_c),
      .hit_o(bank_hit[b])
    );
  end

  sdr_bus_track #(
    .BANK_W    (BANK_W),
    .RRD_CYC   (RRD_CYC),
    .RRD_W     (RRD_W),
    .WR_RCV_CYC(WR_RCV_CYC),
    .WRC_W     (WRC_W),
    .CAS_LAT   (CAS_LAT)
  ) bus_i (
    .clk        (clk),
    .rst        (rst),
    .cmd_i      (cmd_c),
    .bank_i     (bank_i),
    .wr_dv_i    (wr_dv_i),
    .hit_o      (bus_hit),
    .cut_vld_o  (cut_vld),
    .cut_words_o(cut_words)
  );

  always_comb begin
    all_hit = bus_hit;
    for (int b = 0; b < NUM_BANKS; b++) all_hit = all_hit | bank_hit[b];
  end

  sdr_err_sticky err_i (
    .clk   (clk),
    .rst   (rst),
    .clr_i (err_clr_i),
    .hit_i (all_hit),
    .code_o(code)
  );

  assign err_code_o = code;

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_o         <= '0;
      rd_cut_vld_o   <= 1'b0;
      rd_cut_words_o <= '0;
    end else begin
      viol_o         <= all_hit;
      rd_cut_vld_o   <= cut_vld;
      rd_cut_words_o <= cut_vld ? cut_words : 2'd0;
    end
  end

endmodule

// File: rtl/sdr_cmd_spacing_mon_chk.sv
module sdr_cmd_spacing_mon_chk
  import sdr_mon_pkg::*;
#(
  parameter int BANK_W  = 1,
  parameter int CAS_LAT = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        cmd_i,
  input logic [BANK_W-1:0] bank_i,
  input logic              wr_dv_i,
  input logic              err_clr_i,
  input logic [9:0]        viol_o,
  input logic [3:0]        err_code_o,
  input logic              rd_cut_vld_o,
  input logic [1:0]        rd_cut_words_o
);

  // R2
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (viol_o == '0 && err_code_o == '0 && !rd_cut_vld_o));

  // R8
  col_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == CMD_RD || cmd_i == CMD_WR) |=>
      (!viol_o[RULE_RRD] && !viol_o[RULE_RP] && !viol_o[RULE_RC] &&
       !viol_o[RULE_RAS_MIN] && !viol_o[RULE_RDL] && !viol_o[RULE_BDL]));

  // R6
  act_rule_set_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == CMD_ACT) |=>
      (!viol_o[RULE_CDL] && !viol_o[RULE_RDL] && !viol_o[RULE_BDL] &&
       !viol_o[RULE_RCD] && !viol_o[RULE_RAS_MIN]));

  // R12
  nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == CMD_NOP) |=> ((viol_o & ~(10'd1 << RULE_RAS_MAX)) == '0));

  // R11
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (err_code_o != '0 && !err_clr_i) |=> $stable(err_code_o));

  // R11
  code_source_chk: assert property (@(posedge clk) disable iff (rst)
    (err_code_o == '0) |=> (err_code_o == '0 || viol_o != '0));

  // R10
  cut_words_chk: assert property (@(posedge clk) disable iff (rst)
    rd_cut_vld_o |-> (rd_cut_words_o == 2'(CAS_LAT - 1)));

  // R10
  cut_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd_i == CMD_PRE || cmd_i == CMD_BST) |=> !rd_cut_vld_o);

endmodule

bind sdr_cmd_spacing_mon sdr_cmd_spacing_mon_chk #(
  .BANK_W (BANK_W),
  .CAS_LAT(CAS_LAT)
) chk_i (
  .clk           (clk),
  .rst           (rst),
  .cmd_i         (cmd_i),
  .bank_i        (bank_i),
  .wr_dv_i       (wr_dv_i),
  .err_clr_i     (err_clr_i),
  .viol_o        (viol_o),
  .err_code_o    (err_code_o),
  .rd_cut_vld_o  (rd_cut_vld_o),
  .rd_cut_words_o(rd_cut_words_o)
);

// File: tb/sdr_cmd_spacing_mon_tb_top.sv
`timescale 1ns/1ps
module sdr_cmd_spacing_mon_tb_top;

  localparam int PER_PS = 8000;
  localparam int CL     = 3;

  function automatic int to_cyc(input int ns);
    return (ns * 1000 + PER_PS - 1) / PER_PS;
  endfunction

  localparam int C_RRD    = to_cyc(14);
  localparam int C_RCD    = to_cyc(21);
  localparam int C_RP     = to_cyc(21);
  localparam int C_RASMIN = to_cyc(49);
  localparam int C_RC     = to_cyc(70);
  localparam int C_RASMAX = to_cyc(100000);

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                         PRE = 3'd4, BST = 3'd5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cmd_i = NOP;
  logic [0:0] bank_i = 1'b0;
  logic       wr_dv_i = 1'b0;
  logic       err_clr_i = 1'b0;
  logic [9:0] viol_o;
  logic [3:0] err_code_o;
  logic       rd_cut_vld_o;
  logic [1:0] rd_cut_words_o;

  int  total = 0;
  int  fails = 0;
  bit  done  = 1'b0;

  longint cyc = 0;
  longint last_act [2];
  longint last_pre [2];
  bit     is_open  [2];
  longint last_any_act;
  int     last_bank;
  bit     rd_open;
  logic [3:0] exp_err;

  always #4 clk = ~clk;

  sdr_cmd_spacing_mon dut_i (
    .clk(clk), .rst(rst), .cmd_i(cmd_i), .bank_i(bank_i),
    .wr_dv_i(wr_dv_i), .err_clr_i(err_clr_i), .viol_o(viol_o),
    .err_code_o(err_code_o), .rd_cut_vld_o(rd_cut_vld_o),
    .rd_cut_words_o(rd_cut_words_o)
  );

  function automatic logic [3:0] enc(input logic [9:0] v);
    for (int i = 0; i < 10; i++) if (v[i]) return 4'(i + 1);
    return 4'd0;
  endfunction

  task automatic check(input string tag, input string what, input longint act_v,
                       input longint exp_v);
    total++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s %s got %0h exp %0h", tag, what, act_v, exp_v);
    end
  endtask

  task automatic step(input logic [2:0] c, input int b, input bit wdv,
                      input bit clr, input string tag);
    logic [9:0] e;
    bit cv;
    cmd_i = c; bank_i = 1'(b); wr_dv_i = wdv; err_clr_i = clr;
    e = '0;
    for (int k = 0; k < 2; k++)
      if (is_open[k] && cyc - last_act[k] == C_RASMAX && !(c == PRE && b == k)) e[5] = 1'b1;
    case (c)
      ACT: begin
        if (b != last_bank && cyc - last_any_act < C_RRD) e[1] = 1'b1;
        if (is_open[b]) e[0] = 1'b1;
        else begin
          if (cyc - last_pre[b] < C_RP) e[3] = 1'b1;
          if (cyc - last_act[b] < C_RC) e[6] = 1'b1;
        end
      end
      RD, WR: begin
        if (!is_open[b]) e[0] = 1'b1;
        else if (cyc - last_act[b] < C_RCD) e[2] = 1'b1;
        if (c == RD && wdv) e[7] = 1'b1;
      end
      PRE: begin
        if (is_open[b] && cyc - last_act[b] < C_RASMIN) e[4] = 1'b1;
        if (wdv) e[8] = 1'b1;
      end
      BST: if (wdv) e[9] = 1'b1;
      default: ;
    endcase
    cv = rd_open && (c == PRE || c == BST);
    if (c == ACT) begin
      last_any_act = cyc; last_bank = b;
      if (!is_open[b]) begin is_open[b] = 1'b1; last_act[b] = cyc; end
    end
    if (c == PRE && is_open[b]) begin is_open[b] = 1'b0; last_pre[b] = cyc; end
    if (c == RD) rd_open = 1'b1;
    else if (c == WR || c == PRE || c == BST) rd_open = 1'b0;
    if (clr || exp_err == 4'd0) exp_err = enc(e);
    cyc++;
    @(posedge clk);
    @(negedge clk);
    check(tag, "viol_o", longint'(viol_o), longint'(e));
    check((tag == "R12") ? "R11" : tag, "err_code_o", longint'(err_code_o), longint'(exp_err));
    check((tag == "R12") ? "R10" : tag, "rd_cut_vld_o", longint'(rd_cut_vld_o), longint'(cv));
    if (cv) check("R10", "rd_cut_words_o", longint'(rd_cut_words_o), longint'(CL - 1));
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(NOP, 0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL R12 watchdog got running exp finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h5eed);
    for (int k = 0; k < 2; k++) begin
      last_act[k] = -1000000; last_pre[k] = -1000000; is_open[k] = 1'b0;
    end
    last_any_act = -1000000; last_bank = 0; rd_open = 1'b0; exp_err = 4'd0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R2 reset state at the ports
    check("R2", "viol_o", longint'(viol_o), 0);
    check("R2", "err_code_o", longint'(err_code_o), 0);
    check("R2", "rd_cut_vld_o", longint'(rd_cut_vld_o), 0);
    // R2 first command after reset is clean
    step(ACT, 0, 1'b0, 1'b0, "R2");
    // R3 open other bank one cycle later
    step(ACT, 1, 1'b0, 1'b0, "R3");
    check("R11", "first code", longint'(err_code_o), 2);
    // R4 column command too early, then at the limit
    step(RD, 0, 1'b0, 1'b0, "R4");
    step(RD, 0, 1'b0, 1'b0, "R4");
    // R5 close too early
    step(PRE, 0, 1'b0, 1'b0, "R5");
    // R6 reopen at once: close-to-open and open-to-open
    step(ACT, 0, 1'b0, 1'b0, "R6");
    // R9 open an open bank
    step(ACT, 0, 1'b0, 1'b0, "R9");
    idle(C_RASMIN, "R12");
    step(PRE, 1, 1'b0, 1'b0, "R5");
    // R9 read a closed bank, close a closed bank
    step(RD, 1, 1'b0, 1'b0, "R9");
    step(PRE, 1, 1'b0, 1'b0, "R9");
    // R11 clear
    step(NOP, 0, 1'b0, 1'b1, "R11");
    check("R11", "cleared", longint'(err_code_o), 0);
    // R8 write recovery, back-to-back writes
    step(WR, 0, 1'b1, 1'b0, "R8");
    step(WR, 0, 1'b1, 1'b0, "R8");
    step(RD, 0, 1'b1, 1'b0, "R8");
    step(BST, 0, 1'b1, 1'b0, "R8");
    step(PRE, 0, 1'b1, 1'b0, "R8");
    step(RD, 0, 1'b0, 1'b0, "R9");
    // R1 open-to-column boundary: distance 2 flags, 3 passes
    idle(C_RC, "R12");
    step(ACT, 1, 1'b0, 1'b1, "R1");
    step(NOP, 0, 1'b0, 1'b0, "R1");
    step(RD, 1, 1'b0, 1'b0, "R1");
    step(RD, 1, 1'b0, 1'b0, "R1");
    // R10 read cut by burst stop and by close
    step(BST, 1, 1'b0, 1'b0, "R10");
    step(RD, 1, 1'b0, 1'b0, "R10");
    idle(C_RASMIN, "R12");
    step(PRE, 1, 1'b0, 1'b0, "R10");
    step(BST, 1, 1'b0, 1'b0, "R10");
    // R7 open time expiry
    idle(C_RC, "R12");
    step(ACT, 1, 1'b0, 1'b1, "R7");
    idle(C_RASMAX + 1, "R7");
    step(PRE, 1, 1'b0, 1'b0, "R7");
    // R12 random stream
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [2:0] c;
      r = $urandom_range(0, 9);
      c = (r < 3) ? NOP : (r < 5) ? ACT : (r == 5) ? RD : (r == 6) ? WR : (r < 9) ? PRE : BST;
      step(c, $urandom_range(0, 1), (c == WR) || ($urandom_range(0, 5) == 0),
           $urandom_range(0, 40) == 0, "R12");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule